// File: doc/BRIEF.md
# Serial Word Receiver with Write Strobe Regeneration

This block sits at the display end of a two-wire serial link. It takes a forwarded serial clock and a serial data line and brings both into the local clock domain. It waits for a start marker, then gathers one 20-bit word and places it on a parallel bus. After that it issues an active-low write strobe. A display controller on the bus therefore sees one write pulse per word sent by the host, and the data is stable before the strobe falls.

The receiver has three modes. When the active-low reset is low, the bus is forced to zero and the strobe is held high. When the standby request is low, the bus keeps its last word, the strobe stays high, and any frame in progress is thrown away. When neither input is low, the receiver runs normally.

If the forwarded clock stops in the middle of a frame, a timeout drops the partial word. The edge-rate select pin has no effect on the logic. It is only captured into a status register.

Top module: `serial_word_rx`

## Requirements
- R1: While `rst_n` is low, `par_data` is all zeros, `wr_strobe_n` is 1 and `rate_fast_q` is 0.
- R2: In idle, a rising edge of `ser_clk` starts a frame only if `ser_dat` is 1 at that edge. Rising edges with `ser_dat` at 0 produce no word and no strobe.
- R3: After the start bit, the next 20 rising edges of `ser_clk` supply the word least significant bit first: the first data bit becomes `par_data[0]` and the twentieth becomes `par_data[19]`.
- R4: `par_data` takes the new word at least one local clock cycle before `wr_strobe_n` falls, and it does not change in the cycle in which the strobe falls.
- R5: `wr_strobe_n` idles at 1. For each completed word it goes low exactly once, for exactly `PULSE_CYC` local clock cycles (default 4).
- R6: While `standby_n` is low, `wr_strobe_n` is 1 and `par_data` keeps its last value. A frame that is in progress, or that is sent during standby, produces no word.
- R7: If no rising edge of `ser_clk` arrives for `TIMEOUT_CYC` local cycles (default 64) during a frame, the partial word is discarded and the receiver waits for a new start bit.
- R8: `rate_fast_q` is `edge_sel` delayed by one local clock. It has no effect on `par_data` or `wr_strobe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset (reset mode) |
| standby_n | input | 1 | Active-low standby request |
| edge_sel | input | 1 | Output edge-rate select, 0 slow, 1 fast |
| ser_clk | input | 1 | Forwarded serial clock |
| ser_dat | input | 1 | Serial data, valid at `ser_clk` rising edges |
| par_data | output | 20 | Parallel output word |
| wr_strobe_n | output | 1 | Regenerated active-low write strobe |
| rate_fast_q | output | 1 | Registered edge-rate select |

## Verification
A bit counter or shift register in the wrong state shows up on `par_data`. The bus then carries a word that is rotated, shifted or mixed with stale bits, and this can be seen at the first strobe after the frame ends. A wrong strobe sequencer shows up as a pulse that is too long or too short, a pulse that repeats, or a pulse that falls while the data is still changing. All of these are visible within a few local cycles of the word completing. A timeout or standby path that fails to clear the receiver leaves stale bits behind. Those stale bits corrupt the next full frame, so the bench always sends a clean word after each partial or suppressed frame and checks it.

// File: rtl/serial_word_rx_pkg.sv
package serial_word_rx_pkg;
   typedef enum logic {
      FR_IDLE,
      FR_COLLECT
   } frame_state_e;

   typedef enum logic [1:0] {
      WS_IDLE,
      WS_SETUP,
      WS_LOW
   } strobe_state_e;
endpackage

// File: rtl/swr_sync.sv
module swr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ser_clk,
   input  logic ser_dat,
   output logic clk_rise,
   output logic dat_s
);
   logic [STAGES-1:0] clk_chain;
   logic [STAGES-1:0] dat_chain;
   logic              clk_last;

   if (STAGES < 2) begin : g_bad_stages
      $error("swr_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clk_chain[0] <= 1'b0;
               dat_chain[0] <= 1'b0;
            end else begin
               clk_chain[0] <= ser_clk;
               dat_chain[0] <= ser_dat;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clk_chain[i] <= 1'b0;
               dat_chain[i] <= 1'b0;
            end else begin
               clk_chain[i] <= clk_chain[i-1];
               dat_chain[i] <= dat_chain[i-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_last <= 1'b0;
      else        clk_last <= clk_chain[STAGES-1];
   end

   assign clk_rise = clk_chain[STAGES-1] & ~clk_last;
   assign dat_s    = dat_chain[STAGES-1];
endmodule

// File: rtl/swr_deframer.sv
module swr_deframer
   import serial_word_rx_pkg::*;
#(
   parameter int WORD_W      = 20,
   parameter int TIMEOUT_CYC = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby_n,
   input  logic              clk_rise,
   input  logic              dat_s,
   output logic              word_vld,
   output logic [WORD_W-1:0] word
);
   localparam int CNT_W = $clog2(WORD_W);
   localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);

   frame_state_e      state;
   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  bit_cnt;
   logic [TMO_W-1:0]  idle_cnt;

   if (WORD_W < 2) begin : g_bad_width
      $error("swr_deframer: WORD_W must be at least 2");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_tmo
      $error("swr_deframer: TIMEOUT_CYC must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= FR_IDLE;
         shreg    <= '0;
         bit_cnt  <= '0;
         idle_cnt <= '0;
         word_vld <= 1'b0;
         word     <= '0;
      end else begin
         word_vld <= 1'b0;
         if (!standby_n) begin
            state    <= FR_IDLE;
            bit_cnt  <= '0;
            idle_cnt <= '0;
         end else begin
            case (state)
               FR_IDLE: begin
                  if (clk_rise && dat_s) begin
                     state    <= FR_COLLECT;
                     bit_cnt  <= '0;
                     idle_cnt <= '0;
                  end
               end
               FR_COLLECT: begin
                  if (clk_rise) begin
                     shreg    <= {dat_s, shreg[WORD_W-1:1]};
                     idle_cnt <= '0;
                     if (bit_cnt == CNT_W'(WORD_W - 1)) begin
                        word     <= {dat_s, shreg[WORD_W-1:1]};
                        word_vld <= 1'b1;
                        state    <= FR_IDLE;
                     end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end else if (idle_cnt == TMO_W'(TIMEOUT_CYC - 1)) begin
                     state <= FR_IDLE;
                  end else begin
                     idle_cnt <= idle_cnt + 1'b1;
                  end
               end
               default: state <= FR_IDLE;
            endcase
         end
      end
   end

   assert_bitcnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt < CNT_W'(WORD_W));
   assert_timeout_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FR_COLLECT) |-> (idle_cnt < TMO_W'(TIMEOUT_CYC)));
   assert_word_from_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |-> $past(state == FR_COLLECT));
   assert_standby_no_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !standby_n |=> !word_vld);
endmodule

// File: rtl/swr_strobe_gen.sv
module swr_strobe_gen
   import serial_word_rx_pkg::*;
#(
   parameter int WORD_W    = 20,
   parameter int PULSE_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby_n,
   input  logic              word_vld,
   input  logic [WORD_W-1:0] word,
   output logic [WORD_W-1:0] par_data,
   output logic              wr_strobe_n
);
   localparam int PC_W = $clog2(PULSE_CYC + 1);
   localparam int LL_W = $clog2(PULSE_CYC + 2);

   strobe_state_e    state;
   logic [PC_W-1:0]  pulse_cnt;
   logic [LL_W-1:0]  low_len;

   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("swr_strobe_gen: PULSE_CYC must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= WS_IDLE;
         par_data    <= '0;
         wr_strobe_n <= 1'b1;
         pulse_cnt   <= '0;
      end else if (!standby_n) begin
         state       <= WS_IDLE;
         wr_strobe_n <= 1'b1;
         pulse_cnt   <= '0;
      end else if (word_vld) begin
         par_data    <= word;
         wr_strobe_n <= 1'b1;
         state       <= WS_SETUP;
      end else begin
         case (state)
            WS_SETUP: begin
               wr_strobe_n <= 1'b0;
               pulse_cnt   <= PC_W'(PULSE_CYC - 1);
               state       <= WS_LOW;
            end
            WS_LOW: begin
               if (pulse_cnt == '0) begin
                  wr_strobe_n <= 1'b1;
                  state       <= WS_IDLE;
               end else begin
                  pulse_cnt <= pulse_cnt - 1'b1;
               end
            end
            default: state <= WS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            low_len <= '0;
      else if (!wr_strobe_n) low_len <= low_len + 1'b1;
      else                   low_len <= '0;
   end

   assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      low_len <= LL_W'(PULSE_CYC));
   assert_data_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_strobe_n) |-> $stable(par_data));
   assert_strobe_high_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !standby_n |=> wr_strobe_n);
   assert_data_hold_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !standby_n |=> $stable(par_data));
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx #(
   parameter int WORD_W      = 20,
   parameter int PULSE_CYC   = 4,
   parameter int TIMEOUT_CYC = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby_n,
   input  logic              edge_sel,
   input  logic              ser_clk,
   input  logic              ser_dat,
   output logic [WORD_W-1:0] par_data,
   output logic              wr_strobe_n,
   output logic              rate_fast_q
);
   logic              clk_rise;
   logic              dat_s;
   logic              word_vld;
   logic [WORD_W-1:0] word;

   swr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_clk  (ser_clk),
      .ser_dat  (ser_dat),
      .clk_rise (clk_rise),
      .dat_s    (dat_s)
   );

   swr_deframer #(.WORD_W(WORD_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_deframer (
      .clk       (clk),
      .rst_n     (rst_n),
      .standby_n (standby_n),
      .clk_rise  (clk_rise),
      .dat_s     (dat_s),
      .word_vld  (word_vld),
      .word      (word)
   );

   swr_strobe_gen #(.WORD_W(WORD_W), .PULSE_CYC(PULSE_CYC)) u_strobe (
      .clk         (clk),
      .rst_n       (rst_n),
      .standby_n   (standby_n),
      .word_vld    (word_vld),
      .word        (word),
      .par_data    (par_data),
      .wr_strobe_n (wr_strobe_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rate_fast_q <= 1'b0;
      else        rate_fast_q <= edge_sel;
   end

   assert_rate_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (rate_fast_q == $past(edge_sel)));
endmodule

// File: tb/serial_word_rx_tb.sv
module serial_word_rx_tb;
   localparam int W     = 20;
   localparam int PULSE = 4;
   localparam int HALF  = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         standby_n = 1'b1;
   logic         edge_sel = 1'b0;
   logic         ser_clk = 1'b0;
   logic         ser_dat = 1'b0;
   logic [W-1:0] par_data;
   logic         wr_strobe_n;
   logic         rate_fast_q;

   int n_checks = 0;
   int n_fail   = 0;
   int falls    = 0;
   int cur_low  = 0;
   logic         prev_strobe = 1'b1;
   logic [W-1:0] prev_data = '0;
   logic [W-1:0] captured = '0;
   bit           finished = 0;

   always #5 clk = ~clk;

   serial_word_rx u_dut (
      .clk(clk), .rst_n(rst_n), .standby_n(standby_n), .edge_sel(edge_sel),
      .ser_clk(ser_clk), .ser_dat(ser_dat), .par_data(par_data),
      .wr_strobe_n(wr_strobe_n), .rate_fast_q(rate_fast_q)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic frame_bit(input logic [W-1:0] w, input int i);
      return w[i];
   endfunction

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ser_edge(input logic b);
      ser_dat = b;
      wait_n(HALF);
      ser_clk = 1'b1;
      wait_n(HALF);
      ser_clk = 1'b0;
   endtask

   task automatic send_bits(input logic [W-1:0] w, input int nbits);
      ser_edge(1'b1);
      for (int i = 0; i < nbits; i++) ser_edge(frame_bit(w, i));
      ser_dat = 1'b0;
   endtask

   task automatic send_and_check(input logic [W-1:0] w, input string req);
      int f0;
      f0 = falls;
      send_bits(w, W);
      wait_n(20);
      check(falls == f0 + 1, "R5 one strobe per word", 32'(falls - f0), 32'd1);
      check(captured == w, req, 32'(captured), 32'(w));
      check(wr_strobe_n == 1'b1, "R5 strobe idles high", 32'(wr_strobe_n), 32'd1);
   endtask

   // strobe monitor: edge count, data setup (R4), pulse width (R5)
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_strobe && !wr_strobe_n) begin
            falls++;
            captured = par_data;
            check(par_data == prev_data, "R4 data stable at strobe fall",
                  32'(par_data), 32'(prev_data));
         end
         if (!wr_strobe_n) cur_low++;
         else if (cur_low != 0) begin
            check(cur_low == PULSE, "R5 strobe low width", 32'(cur_low), 32'(PULSE));
            cur_low = 0;
         end
      end
      prev_strobe = wr_strobe_n;
      prev_data   = par_data;
   end

   initial begin
      logic [W-1:0] w;
      int f0;
      void'($urandom(32'h5EED_1234));
      wait_n(3);
      check(par_data == '0, "R1 reset data low", 32'(par_data), 32'd0);
      check(wr_strobe_n == 1'b1, "R1 reset strobe high", 32'(wr_strobe_n), 32'd1);
      check(rate_fast_q == 1'b0, "R1 reset status", 32'(rate_fast_q), 32'd0);
      rst_n = 1'b1;
      wait_n(3);

      // R3 directed corner words
      send_and_check(20'h00001, "R3 lsb first single bit");
      send_and_check(20'h80000, "R3 msb position");
      send_and_check(20'hFFFFF, "R3 all ones");
      send_and_check(20'h00000, "R3 all zeros");
      // R3 random words
      for (int k = 0; k < 12; k++) begin
         w = W'($urandom());
         send_and_check(w, "R3 random word");
      end

      // R2: edges with data 0 in idle produce nothing
      f0 = falls;
      for (int k = 0; k < 10; k++) ser_edge(1'b0);
      wait_n(20);
      check(falls == f0, "R2 no start without marker", 32'(falls), 32'(f0));
      check(par_data == w, "R2 data unchanged", 32'(par_data), 32'(w));
      send_and_check(20'h5A5A5, "R2 frame after idle edges");

      // R6: standby discards frame in progress and holds data
      send_bits(20'h12345, 9);
      standby_n = 1'b0;
      wait_n(3);
      check(wr_strobe_n == 1'b1, "R6 strobe high in standby", 32'(wr_strobe_n), 32'd1);
      f0 = falls;
      send_bits(20'hABCDE, W);
      wait_n(20);
      check(falls == f0, "R6 no strobe in standby", 32'(falls), 32'(f0));
      check(par_data == 20'h5A5A5, "R6 data held in standby", 32'(par_data), 32'h5A5A5);
      standby_n = 1'b1;
      wait_n(3);
      send_and_check(20'h0F0F3, "R6 clean word after standby");

      // R7: stalled partial frame is dropped
      f0 = falls;
      send_bits(20'hFFFFF, 8);
      wait_n(100);
      check(falls == f0, "R7 no strobe for partial", 32'(falls), 32'(f0));
      check(par_data == 20'h0F0F3, "R7 data unchanged", 32'(par_data), 32'h0F0F3);
      send_and_check(20'h00C81, "R7 clean word after timeout");

      // R8: edge select is status only
      edge_sel = 1'b1;
      wait_n(2);
      check(rate_fast_q == 1'b1, "R8 status follows select", 32'(rate_fast_q), 32'd1);
      check(par_data == 20'h00C81, "R8 no effect on data", 32'(par_data), 32'h00C81);
      check(wr_strobe_n == 1'b1, "R8 no effect on strobe", 32'(wr_strobe_n), 32'd1);
      send_and_check(20'h3C3C3, "R8 word with fast select");
      edge_sel = 1'b0;
      wait_n(2);
      check(rate_fast_q == 1'b0, "R8 status cleared", 32'(rate_fast_q), 32'd0);

      // R1: reset after operation
      rst_n = 1'b0;
      wait_n(2);
      check(par_data == '0, "R1 reset clears data", 32'(par_data), 32'd0);
      check(wr_strobe_n == 1'b1, "R1 reset strobe high", 32'(wr_strobe_n), 32'd1);

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule